// File: doc/BRIEF.md
# Event Qualification Protocol Engine

This block decides, on every clock of an already-selected test clock, whether a bus monitor should sample the watched bus, write it into capture memory, and fold it into a running signature. It compares the monitored bus with two stored patterns. One is the start pattern and the other is the stop or pause pattern. Each pattern has its own per-bit mask, and the two comparisons produce local events. A 3-bit protocol code selects one of eight run-time behaviours. The behaviours are always active, start then run until stop, start with pause and resume, and do-while. Each of the four runs either from the local pattern matches or from an external event input.

Configuration is written through a small address/data write port. A synchronous clear returns the protocol logic to idle. A run input must be high before any protocol can leave idle. The block drives three operation enables. It also drives a registered event output that can carry either local match, the activity state, or the union of both matches, for use by external qualification logic.

Top module: `evq_engine`

## Requirements
- R1: After reset, all four outputs are 0, both patterns and both masks are 0, and the control word is 0. The control word holds protocol 0, event select 0 and all operation enables off.
- R2: A pattern matches when every bus bit whose mask bit is 0 equals the pattern bit. Mask bit 1 means the bus bit is ignored. The write map is: address 0 start pattern, 1 start mask, 2 stop/pause pattern, 3 stop/pause mask, 4 control.
- R3: Control bits [5:4] pick the event output: 0 start match, 1 stop match, 2 the activity state, 3 either match. The output is registered and reflects the bus value seen at the previous clock edge.
- R4: Protocol code 0 (control bits [2:0]) becomes active at the first edge with run high and stays active until cleared.
- R5: Protocol 1 goes active on a start event and moves to a finished state on a stop event seen while active. The finished state holds, ignoring further start events, until a clear.
- R6: Protocol 2 goes active on a start event. While active, a stop/pause event pauses it, and while paused, a start event resumes it.
- R7: Protocol 3 is active in the cycle after each edge where the start event is true. It falls back to idle after an edge where the event is false.
- R8: Codes 4 to 7 behave like codes 0 to 3, except that the external event input serves as both the start event and the stop/pause event.
- R9: With run low, an idle protocol stays idle whatever the events are.
- R10: A clear input high at an edge forces idle, and all three enables are 0 after that edge. Clear wins over every other condition.
- R11: Control bits 6, 7 and 8 gate the sample, store and compress enables individually. Each enable is high only in the active state.
- R12: Writes to addresses 5 to 7 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected test clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous protocol clear |
| run | input | 1 | Permission to leave idle |
| bus_i | input | BUS_W | Monitored bus |
| ext_evt_i | input | 1 | External event |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | BUS_W | Configuration write data |
| samp_en | output | 1 | Sample enable |
| store_en | output | 1 | Memory store enable |
| comp_en | output | 1 | Signature compression enable |
| evt_out | output | 1 | Registered event output |

## Verification
The hardest states to reach are the finished state of the start/stop protocol and the paused state of the pause/resume protocol. Each needs a specific ordering of two different masked matches, and on a random 16-bit bus those matches almost never happen. The stimulus therefore draws half of its bus values from the stored patterns with random noise placed only in masked bits, so that both events occur often and in every order. Directed sequences then drive start, stop, a second start and a clear in a fixed order, to show that the finished state holds.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int NPAT          = 2;
  localparam int CTL_W         = 9;
  localparam int CTL_PROTO_LSB = 0;
  localparam int CTL_SEL_LSB   = 4;
  localparam int CTL_OP_LSB    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_DONE  = 2'd3
  } evq_state_e;

  typedef enum logic [1:0] {
    K_ALWAYS    = 2'd0,
    K_STARTSTOP = 2'd1,
    K_PAUSE     = 2'd2,
    K_WHILE     = 2'd3
  } evq_kind_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_STOP  = 2'd1,
    SEL_ACT   = 2'd2,
    SEL_ANY   = 2'd3
  } evq_sel_e;
endpackage

// File: rtl/evq_cfg.sv
module evq_cfg
  import evq_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [W-1:0]              wdata,
  output logic [NPAT-1:0][W-1:0]    pat_o,
  output logic [NPAT-1:0][W-1:0]    msk_o,
  output logic [CTL_W-1:0]          ctl_o
);
  localparam int CTL_ADDR = 2 * NPAT;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[W-1:CTL_W];

  for (genvar i = 0; i < NPAT; i++) begin : g_pat
    always_ff @(posedge clk) begin
      if (rst) begin
        pat_o[i] <= '0;
        msk_o[i] <= '0;
      end else if (we) begin
        if (addr == AW'(2 * i))     pat_o[i] <= wdata;
        if (addr == AW'(2 * i + 1)) msk_o[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 ctl_o <= '0;
    else if (we && addr == AW'(CTL_ADDR))    ctl_o <= wdata[CTL_W-1:0];
  end

  // R12: addresses beyond the control word leave the control word alone
  a_r12_ctl_unused_addr: assert property (@(posedge clk) disable iff (rst)
    (we && addr > AW'(CTL_ADDR)) |=> $stable(ctl_o));
endmodule

// File: rtl/evq_match.sv
module evq_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] msk_i,
  input  logic [W-1:0] bus_i,
  output logic         hit_o
);
  logic [W-1:0] diff;

  assign diff  = (bus_i ^ pat_i) & ~msk_i;
  assign hit_o = (diff == '0);

  // R2: a fully masked pattern always matches; an exact value always matches
  a_r2_all_masked_hits: assert property (@(posedge clk) disable iff (rst)
    (&msk_i) |-> hit_o);
  a_r2_exact_value_hits: assert property (@(posedge clk) disable iff (rst)
    (bus_i == pat_i) |-> hit_o);
endmodule

// File: rtl/evq_proto.sv
module evq_proto
  import evq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [2:0] proto_i,
  input  logic       start_hit_i,
  input  logic       stop_hit_i,
  input  logic       ext_evt_i,
  output logic       act_o,
  output logic       nxt_act_o
);
  evq_state_e st_q, nxt;
  evq_kind_e  kind;
  logic       use_ext, sev, pev;

  assign kind    = evq_kind_e'(proto_i[1:0]);
  assign use_ext = proto_i[2];
  assign sev     = use_ext ? ext_evt_i : start_hit_i;
  assign pev     = use_ext ? ext_evt_i : stop_hit_i;

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_IDLE: if (run_i && (kind == K_ALWAYS || sev)) nxt = ST_ACT;
      ST_ACT: begin
        unique case (kind)
          K_ALWAYS:    nxt = ST_ACT;
          K_STARTSTOP: if (pev)  nxt = ST_DONE;
          K_PAUSE:     if (pev)  nxt = ST_PAUSE;
          default:     if (!sev) nxt = ST_IDLE;
        endcase
      end
      ST_PAUSE: if (sev) nxt = ST_ACT;
      default:  nxt = ST_DONE;
    endcase
    if (clr_i) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= nxt;
  end

  assign act_o     = (st_q == ST_ACT);
  assign nxt_act_o = (nxt == ST_ACT);

  a_r9_idle_needs_run: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !run_i) |=> (st_q == ST_IDLE));
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && !clr_i) |=> (st_q == ST_DONE));
  a_r10_clear_to_idle: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (st_q == ST_IDLE));
  a_r7_while_drops: assert property (@(posedge clk) disable iff (rst)
    (kind == K_WHILE && !sev && (st_q == ST_IDLE || st_q == ST_ACT)) |=> (st_q == ST_IDLE));
  a_r6_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAUSE && !sev && !clr_i) |=> (st_q == ST_PAUSE));
endmodule

// File: rtl/evq_engine.sv
module evq_engine
  import evq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              run,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic              ext_evt_i,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BUS_W-1:0]  cfg_wdata,
  output logic              samp_en,
  output logic              store_en,
  output logic              comp_en,
  output logic              evt_out
);
  logic [NPAT-1:0][BUS_W-1:0] pat, msk;
  logic [CTL_W-1:0]           ctl;
  logic [NPAT-1:0]            hit;
  logic                       act, nxt_act;
  evq_sel_e                   sel;

  evq_cfg #(.W(BUS_W), .AW(ADDR_W)) i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pat_o(pat), .msk_o(msk), .ctl_o(ctl)
  );

  for (genvar i = 0; i < NPAT; i++) begin : g_match
    evq_match #(.W(BUS_W)) i_match (
      .clk(clk), .rst(rst), .pat_i(pat[i]), .msk_i(msk[i]),
      .bus_i(bus_i), .hit_o(hit[i])
    );
  end

  evq_proto i_proto (
    .clk(clk), .rst(rst), .clr_i(clr), .run_i(run),
    .proto_i(ctl[CTL_PROTO_LSB +: 3]),
    .start_hit_i(hit[0]), .stop_hit_i(hit[1]), .ext_evt_i(ext_evt_i),
    .act_o(act), .nxt_act_o(nxt_act)
  );

  assign sel = evq_sel_e'(ctl[CTL_SEL_LSB +: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_en  <= 1'b0;
      store_en <= 1'b0;
      comp_en  <= 1'b0;
    end else begin
      samp_en  <= nxt_act & ctl[CTL_OP_LSB];
      store_en <= nxt_act & ctl[CTL_OP_LSB + 1];
      comp_en  <= nxt_act & ctl[CTL_OP_LSB + 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_out <= 1'b0;
    else begin
      unique case (sel)
        SEL_START: evt_out <= hit[0];
        SEL_STOP:  evt_out <= hit[1];
        SEL_ACT:   evt_out <= nxt_act;
        default:   evt_out <= |hit;
      endcase
    end
  end

  a_r11_enables_only_active: assert property (@(posedge clk) disable iff (rst)
    (samp_en || store_en || comp_en) |-> act);
  a_r10_clear_drops_enables: assert property (@(posedge clk) disable iff (rst)
    clr |=> !(samp_en || store_en || comp_en));
  a_r3_active_select: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_ACT) |=> (evt_out == act));
endmodule

// File: tb/test_evq_engine.sv
`timescale 1ns/1ps
module test_evq_engine;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, run = 1'b0, ext = 1'b0, we = 1'b0;
  logic [W-1:0] bus = '0, wdata = '0;
  logic [2:0]   addr = '0;
  logic samp_en, store_en, comp_en, evt_out;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit finished = 1'b0;

  logic [W-1:0] m_pat [2];
  logic [W-1:0] m_msk [2];
  logic [8:0]   m_ctl;
  int           m_st;

  always #2.5 clk = ~clk;

  evq_engine i_evq_engine (
    .clk(clk), .rst(rst), .clr(clr), .run(run), .bus_i(bus), .ext_evt_i(ext),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .samp_en(samp_en), .store_en(store_en), .comp_en(comp_en), .evt_out(evt_out)
  );

  function automatic bit hit(logic [W-1:0] b, logic [W-1:0] p, logic [W-1:0] m);
    return ((b ^ p) & ~m) == '0;
  endfunction

  function automatic logic [W-1:0] near(int i);
    if ($urandom % 2) return m_pat[i] ^ (W'($urandom) & m_msk[i]);
    return W'($urandom);
  endfunction

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, model the rising edge, compare at the next falling edge
  task automatic step(input logic [W-1:0] b, input logic e, input logic r, input logic c,
                      input logic w, input logic [2:0] a, input logic [W-1:0] d);
    bit sh, ph, sev, pev, e_evt;
    int k, nst;
    bus = b; ext = e; run = r; clr = c; we = w; addr = a; wdata = d;
    sh  = hit(b, m_pat[0], m_msk[0]);
    ph  = hit(b, m_pat[1], m_msk[1]);
    k   = int'(m_ctl[1:0]);
    sev = m_ctl[2] ? e : sh;
    pev = m_ctl[2] ? e : ph;
    nst = m_st;
    case (m_st)
      0: if (r && (k == 0 || sev)) nst = 1;
      1: begin
        if (k == 1 && pev) nst = 3;
        else if (k == 2 && pev) nst = 2;
        else if (k == 3 && !sev) nst = 0;
      end
      2: if (sev) nst = 1;
      default: nst = 3;
    endcase
    if (c) nst = 0;
    m_st = nst;
    case (m_ctl[5:4])
      2'd0: e_evt = sh;
      2'd1: e_evt = ph;
      2'd2: e_evt = (nst == 1);
      default: e_evt = sh | ph;
    endcase
    if (w) begin
      case (a)
        3'd0: m_pat[0] = d;
        3'd1: m_msk[0] = d;
        3'd2: m_pat[1] = d;
        3'd3: m_msk[1] = d;
        3'd4: m_ctl    = d[8:0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("samp_en",  samp_en,  (nst == 1) && m_ctl_prev_bit(0));
    chk("store_en", store_en, (nst == 1) && m_ctl_prev_bit(1));
    chk("comp_en",  comp_en,  (nst == 1) && m_ctl_prev_bit(2));
    chk("evt_out",  evt_out,  e_evt);
    prev_ctl = m_ctl;
  endtask

  // operation enable bits as they were before this cycle's write
  logic [8:0] prev_ctl;
  function automatic bit m_ctl_prev_bit(int i);
    return prev_ctl[6 + i];
  endfunction

  task automatic s(input logic [W-1:0] b, input logic e, input logic r);
    step(b, e, r, 1'b0, 1'b0, 3'd0, '0);
  endtask
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    step(bus, 1'b0, run, 1'b0, 1'b1, a, d);
  endtask
  task automatic clr_step();
    step(bus, 1'b0, run, 1'b1, 1'b0, 3'd0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pat[0] = '0; m_pat[1] = '0; m_msk[0] = '0; m_msk[1] = '0;
    m_ctl = '0; prev_ctl = '0; m_st = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values at the ports, then cleared configuration seen through behaviour
    tag = "R1";
    chk("samp_en", samp_en, 1'b0); chk("store_en", store_en, 1'b0);
    chk("comp_en", comp_en, 1'b0); chk("evt_out", evt_out, 1'b0);
    s('0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) s(W'($urandom), 1'b0, 1'b1);

    // R12: writes to unused addresses must not alter the control word or patterns
    tag = "R12";
    clr_step();
    wr(3'd5, '1); wr(3'd6, '1); wr(3'd7, '1);
    s('0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) s(W'($urandom), 1'b0, 1'b1);

    // R2: masked compare on the start pattern
    tag = "R2";
    wr(3'd0, 16'hA5C3); wr(3'd1, 16'h0F00); wr(3'd4, 16'h0000);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'hA5C3 ^ 16'h0A00, 1'b0, 1'b1);
    s(16'hA5C3 ^ 16'h0001, 1'b0, 1'b1);
    s(16'hA5C3 ^ 16'h8000, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) s(near(0), 1'b0, 1'b1);

    // R3: every event output selection
    tag = "R3";
    wr(3'd2, 16'h5A5A); wr(3'd3, 16'h00FF);
    for (int sel = 1; sel < 4; sel++) begin
      clr_step();
      wr(3'd4, W'((sel << 4) | (1 << 6) | 1));
      for (int i = 0; i < 12; i++) s(($urandom % 2) ? near(0) : near(1), 1'b0, 1'b1);
    end

    // R4: always-active protocol, held back by run
    tag = "R4";
    clr_step();
    wr(3'd4, 16'h01E0);
    s(W'($urandom), 1'b0, 1'b0); s(W'($urandom), 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) s(W'($urandom), 1'b0, 1'b1);

    // R5: start, stop, ignored restart, clear
    tag = "R5";
    clr_step();
    wr(3'd4, 16'h01E1);
    s(16'h0000, 1'b0, 1'b1);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'h1111, 1'b0, 1'b1);
    s(16'h5A00, 1'b0, 1'b1);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'hA5C3, 1'b0, 1'b1);
    clr_step();
    for (int i = 0; i < 20; i++) s(($urandom % 2) ? near(0) : near(1), 1'b0, 1'b1);

    // R6: pause and resume
    tag = "R6";
    clr_step();
    wr(3'd4, 16'h01E2);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'h1111, 1'b0, 1'b1);
    s(16'h5A77, 1'b0, 1'b1);
    s(16'h1111, 1'b0, 1'b1);
    s(16'hA5C3, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) s(($urandom % 2) ? near(0) : near(1), 1'b0, 1'b1);

    // R7: do-while
    tag = "R7";
    clr_step();
    wr(3'd4, 16'h01E3);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'hA5C3, 1'b0, 1'b1);
    s(16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) s(near(0), 1'b0, 1'b1);

    // R8: external event variants
    tag = "R8";
    for (int p = 4; p < 8; p++) begin
      clr_step();
      wr(3'd4, W'(16'h01E0 | p));
      for (int i = 0; i < 25; i++) s(($urandom % 2) ? near(0) : near(1), 1'(($urandom % 3) == 0), 1'b1);
    end

    // R9: run low keeps idle despite start matches
    tag = "R9";
    clr_step();
    wr(3'd4, 16'h01E1);
    for (int i = 0; i < 5; i++) s(16'hA5C3, 1'b0, 1'b0);
    wr(3'd4, 16'h01E4);
    for (int i = 0; i < 5; i++) s(16'hA5C3, 1'b1, 1'b0);

    // R10: clear wins while active and while a start matches
    tag = "R10";
    wr(3'd4, 16'h01E0);
    s('0, 1'b0, 1'b1); s('0, 1'b0, 1'b1);
    step(16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, '0);
    wr(3'd4, 16'h01E1);
    step(16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, '0);
    s(16'hA5C3, 1'b0, 1'b1);
    step(16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, '0);

    // R11: each combination of operation enables
    tag = "R11";
    for (int o = 0; o < 8; o++) begin
      clr_step();
      wr(3'd4, W'(o << 6));
      for (int i = 0; i < 3; i++) s(W'($urandom), 1'b0, 1'b1);
    end

    // mixed random traffic over R4 R5 R6 R7 R8 R10 R12
    tag = "random R5 R6 R7 R8";
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] b;
      int r;
      r = $urandom % 100;
      b = ($urandom % 2) ? near(0) : near(1);
      if (r < 3)       step(b, 1'($urandom), 1'b1, 1'b1, 1'b0, 3'd0, '0);
      else if (r < 8)  step(b, 1'($urandom), 1'($urandom % 10 != 0), 1'b0, 1'b1,
                            3'($urandom), W'($urandom));
      else             step(b, 1'(($urandom % 3) == 0), 1'($urandom % 10 != 0), 1'b0, 1'b0,
                            3'd0, '0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule